// File: doc/BRIEF.md
# Input Capture Snapshot Unit

This block holds four 16-bit input-capture registers and four 8-bit pulse accumulators. Each capture register samples a free-running timer value, supplied from outside, when its channel input rises. Each accumulator counts rising edges on its own pulse input and stops counting at 255. Every capture register and every accumulator has a holding register beside it.

A one-cycle force strobe copies all eight live values into their holding registers at the same clock edge. That same edge also clears the accumulators. The strobe acts only while both the latch-mode bit and the buffer-enable bit are high. Otherwise it is ignored.

Software can then read the holding registers at leisure, knowing they form one consistent snapshot. Meanwhile the live counters go on running.

Top module: `icap_snapshot_unit`

## Requirements
- R1: When `cap_in[i]` is low in one cycle and high in the next, capture register i loads `timer_val` at that clock edge. The new value is visible on `cap_vals[16*i +: 16]` after the edge. Without such a rise, the capture register keeps its value.
- R2: Accumulator i (`acc_vals[8*i +: 8]`) adds one for each low-to-high transition of `pulse_in[i]`. An input held high counts only once.
- R3: An accumulator that has reached 255 stays at 255 on further rises.
- R4: A snapshot takes place at a clock edge only when `force_latch`, `latch_mode` and `buf_en` are all 1 at that edge. A strobe held high snapshots at every such edge.
- R5: On a snapshot, every holding capture register takes the value its capture register had before that edge. All four channels are copied at the same edge.
- R6: On a snapshot, every holding accumulator register takes the value its accumulator had before that edge, and the accumulator is cleared.
- R7: A pulse rise in the same cycle as a snapshot is counted into the cleared accumulator, so that accumulator reads 1 afterwards.
- R8: A strobe with `latch_mode` or `buf_en` low leaves the holding registers and the accumulators unchanged.
- R9: While `rst_n` is low, all capture, accumulator and holding outputs read 0.
- R10: If a capture rise and a snapshot share an edge, the holding register gets the old capture value and the capture register gets the new timer value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| timer_val | input | 16 | Free-running timer value to capture |
| cap_in | input | 4 | Capture channel inputs, one per channel |
| pulse_in | input | 4 | Pulse accumulator inputs, one per channel |
| latch_mode | input | 1 | Latch mode enable |
| buf_en | input | 1 | Holding buffer enable |
| force_latch | input | 1 | One-cycle force snapshot strobe |
| cap_vals | output | 64 | Live capture registers, channel i at bits 16*i+15:16*i |
| acc_vals | output | 32 | Live accumulators, channel i at bits 8*i+7:8*i |
| hold_caps | output | 64 | Holding capture registers, same layout as cap_vals |
| hold_accs | output | 32 | Holding accumulator registers, same layout as acc_vals |

## Verification
The assertions assume that every input is synchronous to `clk` and that all inputs are low while reset is applied. With that assumption, the first cycle after reset does not produce a false rise. The bench changes inputs only at falling clock edges and keeps every input at 0 during reset. The strobe is a one-cycle pulse, except where the bench deliberately puts it in the same cycle as a channel edge to exercise the shared-edge cases.

// File: rtl/icap_pkg.sv
package icap_pkg;
  // saturating increment on a value of up to 32 bits, limit given by caller
  function automatic logic [31:0] sat_step(input logic [31:0] v, input logic [31:0] limit);
    return (v >= limit) ? limit : v + 32'd1;
  endfunction

  // a snapshot needs the strobe and both mode bits
  function automatic logic snap_go(input logic strobe, input logic mode, input logic buf_on);
    return strobe & mode & buf_on;
  endfunction
endpackage

// File: rtl/icap_rise_det.sv
module icap_rise_det #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] rise
);
  logic [W-1:0] prev;
  always_ff @(posedge clk) begin
    if (!rst_n) prev <= '0;
    else        prev <= d;
  end
  assign rise = d & ~prev;
endmodule

// File: rtl/icap_capture_reg.sv
module icap_capture_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] value,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= value;
  end
endmodule

// File: rtl/icap_pulse_acc.sv
module icap_pulse_acc #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         step,
  output logic [W-1:0] q
);
  import icap_pkg::*;
  localparam logic [31:0] LIMIT = (32'd1 << W) - 32'd1;
  logic [W-1:0] nxt;

  always_comb begin
    nxt = q;
    if (clr)       nxt = step ? W'(1) : '0;
    else if (step) nxt = W'(sat_step(32'(q), LIMIT));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end
endmodule

// File: rtl/icap_snapshot_unit.sv
module icap_snapshot_unit #(
  parameter int NUM_CH = 4,
  parameter int CAP_W  = 16,
  parameter int ACC_W  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [CAP_W-1:0]        timer_val,
  input  logic [NUM_CH-1:0]       cap_in,
  input  logic [NUM_CH-1:0]       pulse_in,
  input  logic                    latch_mode,
  input  logic                    buf_en,
  input  logic                    force_latch,
  output logic [NUM_CH*CAP_W-1:0] cap_vals,
  output logic [NUM_CH*ACC_W-1:0] acc_vals,
  output logic [NUM_CH*CAP_W-1:0] hold_caps,
  output logic [NUM_CH*ACC_W-1:0] hold_accs
);
  import icap_pkg::*;

  // named internal events, also used by the checker
  logic              snap_fire;
  logic [NUM_CH-1:0] cap_rise;
  logic [NUM_CH-1:0] pulse_rise;

  assign snap_fire = snap_go(force_latch, latch_mode, buf_en);

  icap_rise_det #(.W(NUM_CH)) u_cap_edge (
    .clk(clk), .rst_n(rst_n), .d(cap_in), .rise(cap_rise)
  );
  icap_rise_det #(.W(NUM_CH)) u_pulse_edge (
    .clk(clk), .rst_n(rst_n), .d(pulse_in), .rise(pulse_rise)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    icap_capture_reg #(.W(CAP_W)) u_cap (
      .clk(clk), .rst_n(rst_n), .load(cap_rise[i]), .value(timer_val),
      .q(cap_vals[i*CAP_W +: CAP_W])
    );
    icap_pulse_acc #(.W(ACC_W)) u_acc (
      .clk(clk), .rst_n(rst_n), .clr(snap_fire), .step(pulse_rise[i]),
      .q(acc_vals[i*ACC_W +: ACC_W])
    );
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        hold_caps[i*CAP_W +: CAP_W] <= '0;
        hold_accs[i*ACC_W +: ACC_W] <= '0;
      end else if (snap_fire) begin
        hold_caps[i*CAP_W +: CAP_W] <= cap_vals[i*CAP_W +: CAP_W];
        hold_accs[i*ACC_W +: ACC_W] <= acc_vals[i*ACC_W +: ACC_W];
      end
    end
  end
endmodule

// File: rtl/icap_snapshot_chk.sv
module icap_snapshot_chk #(
  parameter int NUM_CH = 4,
  parameter int CAP_W  = 16,
  parameter int ACC_W  = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [CAP_W-1:0]        timer_val,
  input logic                    snap_fire,
  input logic [NUM_CH-1:0]       cap_rise,
  input logic [NUM_CH-1:0]       pulse_rise,
  input logic [NUM_CH*CAP_W-1:0] cap_vals,
  input logic [NUM_CH*ACC_W-1:0] acc_vals,
  input logic [NUM_CH*CAP_W-1:0] hold_caps,
  input logic [NUM_CH*ACC_W-1:0] hold_accs
);
  localparam logic [ACC_W-1:0] ACC_MAX = '1;

  a_r8_hold_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !snap_fire |=> ($stable(hold_caps) && $stable(hold_accs)));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    a_r1_capture: assert property (@(posedge clk) disable iff (!rst_n)
      cap_rise[i] |=> cap_vals[i*CAP_W +: CAP_W] == $past(timer_val));
    a_r1_capture_keep: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_rise[i] |=> $stable(cap_vals[i*CAP_W +: CAP_W]));
    a_r3_saturate: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_vals[i*ACC_W +: ACC_W] == ACC_MAX && !snap_fire) |=> acc_vals[i*ACC_W +: ACC_W] == ACC_MAX);
    a_r5_hold_cap: assert property (@(posedge clk) disable iff (!rst_n)
      snap_fire |=> hold_caps[i*CAP_W +: CAP_W] == $past(cap_vals[i*CAP_W +: CAP_W]));
    a_r6_hold_acc: assert property (@(posedge clk) disable iff (!rst_n)
      snap_fire |=> hold_accs[i*ACC_W +: ACC_W] == $past(acc_vals[i*ACC_W +: ACC_W]));
    a_r7_clear_count: assert property (@(posedge clk) disable iff (!rst_n)
      snap_fire |=> acc_vals[i*ACC_W +: ACC_W] == ($past(pulse_rise[i]) ? ACC_W'(1) : ACC_W'(0)));
    a_r2_idle_acc: assert property (@(posedge clk) disable iff (!rst_n)
      (!snap_fire && !pulse_rise[i]) |=> $stable(acc_vals[i*ACC_W +: ACC_W]));
  end
endmodule

bind icap_snapshot_unit icap_snapshot_chk #(
  .NUM_CH(NUM_CH), .CAP_W(CAP_W), .ACC_W(ACC_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .timer_val(timer_val), .snap_fire(snap_fire),
  .cap_rise(cap_rise), .pulse_rise(pulse_rise), .cap_vals(cap_vals),
  .acc_vals(acc_vals), .hold_caps(hold_caps), .hold_accs(hold_accs)
);

// File: tb/icap_snapshot_unit_test.sv
`timescale 1ns/1ps
module icap_snapshot_unit_test;
  localparam int N = 4, CW = 16, AW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [CW-1:0] timer_val = '0;
  logic [N-1:0] cap_in = '0, pulse_in = '0;
  logic latch_mode = 1'b0, buf_en = 1'b0, force_latch = 1'b0;
  logic [N*CW-1:0] cap_vals, hold_caps;
  logic [N*AW-1:0] acc_vals, hold_accs;

  int checks = 0, errors = 0;
  int exp_acc [N];
  logic [CW-1:0] exp_cap [N];

  always #2.5 clk = ~clk;

  icap_snapshot_unit uut (
    .clk(clk), .rst_n(rst_n), .timer_val(timer_val), .cap_in(cap_in),
    .pulse_in(pulse_in), .latch_mode(latch_mode), .buf_en(buf_en),
    .force_latch(force_latch), .cap_vals(cap_vals), .acc_vals(acc_vals),
    .hold_caps(hold_caps), .hold_accs(hold_accs)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] capv(input int i);  return 32'(cap_vals[i*CW +: CW]);  endfunction
  function automatic logic [31:0] accv(input int i);  return 32'(acc_vals[i*AW +: AW]);  endfunction
  function automatic logic [31:0] hcapv(input int i); return 32'(hold_caps[i*CW +: CW]); endfunction
  function automatic logic [31:0] haccv(input int i); return 32'(hold_accs[i*AW +: AW]); endfunction

  task automatic pulse(input int ch);
    @(negedge clk) pulse_in[ch] = 1'b1;
    @(negedge clk) pulse_in[ch] = 1'b0;
    exp_acc[ch] = (exp_acc[ch] >= 255) ? 255 : exp_acc[ch] + 1;
  endtask

  task automatic capture(input int ch, input logic [CW-1:0] t);
    @(negedge clk) begin timer_val = t; cap_in[ch] = 1'b1; end
    @(negedge clk) begin cap_in[ch] = 1'b0; timer_val = t + 16'd7; end
    exp_cap[ch] = t;
  endtask

  task automatic strobe(input logic lm, input logic be);
    @(negedge clk) begin latch_mode = lm; buf_en = be; force_latch = 1'b1; end
    @(negedge clk) force_latch = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    for (int i = 0; i < N; i++) begin exp_acc[i] = 0; exp_cap[i] = '0; end
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 cap", 32'(cap_vals != '0), 0);
    chk("R9 acc", 32'(acc_vals != '0), 0);
    chk("R9 hold", 32'((hold_caps != '0) || (hold_accs != '0)), 0);
    rst_n = 1'b1;

    // R1 capture on each channel, distinct timer values
    for (int ch = 0; ch < N; ch++) capture(ch, CW'(16'h1111 * (ch + 1) + ch * 3));
    repeat (4) @(negedge clk);
    for (int ch = 0; ch < N; ch++) chk("R1 capture", capv(ch), 32'(exp_cap[ch]));

    // R2 count a different number of pulses per channel
    for (int ch = 0; ch < N; ch++) for (int k = 0; k < 2 * ch + 3; k++) pulse(ch);
    for (int ch = 0; ch < N; ch++) chk("R2 count", accv(ch), 32'(exp_acc[ch]));
    // R2 held-high input counts once
    @(negedge clk) pulse_in[3] = 1'b1;
    repeat (5) @(negedge clk);
    pulse_in[3] = 1'b0;
    exp_acc[3] = exp_acc[3] + 1;
    @(negedge clk);
    chk("R2 level", accv(3), 32'(exp_acc[3]));

    // R8 and R4: gated strobes are ignored
    strobe(1'b0, 1'b0);
    strobe(1'b1, 1'b0);
    strobe(1'b0, 1'b1);
    for (int ch = 0; ch < N; ch++) begin
      chk("R8 hold cap", hcapv(ch), 0);
      chk("R8 hold acc", haccv(ch), 0);
      chk("R8 acc kept", accv(ch), 32'(exp_acc[ch]));
    end
    // R4: both modes set but no strobe
    @(negedge clk) begin latch_mode = 1'b1; buf_en = 1'b1; end
    repeat (3) @(negedge clk);
    chk("R4 no strobe", haccv(0), 0);

    // R5 R6 effective snapshot
    strobe(1'b1, 1'b1);
    for (int ch = 0; ch < N; ch++) begin
      chk("R5 hold cap", hcapv(ch), 32'(exp_cap[ch]));
      chk("R6 hold acc", haccv(ch), 32'(exp_acc[ch]));
      chk("R6 cleared", accv(ch), 0);
      exp_acc[ch] = 0;
    end

    // R3 saturation
    for (int k = 0; k < 300; k++) pulse(0);
    chk("R3 saturate", accv(0), 255);
    pulse(0);
    chk("R3 stay", accv(0), 255);
    strobe(1'b1, 1'b1);
    chk("R3 hold sat", haccv(0), 255);
    chk("R6 clear sat", accv(0), 0);

    // R7 pulse edge on the snapshot edge
    pulse(2); pulse(2);
    @(negedge clk) begin pulse_in[2] = 1'b1; force_latch = 1'b1; end
    @(negedge clk) begin pulse_in[2] = 1'b0; force_latch = 1'b0; end
    chk("R7 hold", haccv(2), 2);
    chk("R7 counted", accv(2), 1);

    // R10 capture edge on the snapshot edge
    @(negedge clk) begin timer_val = 16'hBEEF; cap_in[1] = 1'b1; force_latch = 1'b1; end
    @(negedge clk) begin cap_in[1] = 1'b0; force_latch = 1'b0; timer_val = 16'h0042; end
    chk("R10 hold old", hcapv(1), 32'(exp_cap[1]));
    chk("R10 cap new", capv(1), 32'h0000BEEF);

    finish_run();
  end
endmodule